// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is an I2C target that behaves as a small byte-addressed nonvolatile memory. It watches open-drain SCL and SDA lines through synchronisers clocked by a fast system clock. It recognises START, repeated START and STOP conditions and compares each device select byte against a fixed 7-bit bus address. When it answers, it pulls SDA low through a single pull-down enable.

Writes arrive as a device select byte with R/W at 0, then one address byte, then one or more data bytes. Each data byte is stored at once at the address counter. The counter then steps within its aligned 16-byte page. Reads use one persistent address counter. A current address read starts at the counter. A random address read first loads the counter through a write that carries only the address, then issues a repeated START. A sequential read goes on for as long as the master acknowledges each byte, and the counter wraps from the top address to zero. A write-lock input refuses data bytes and leaves reads alone. Every location holds FFh after reset.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset every memory location reads FFh and `sda_pull` is 0.
- R2: A byte after START whose bits [7:1] equal `DEV_ADDR` is acknowledged by pulling SDA low during the ninth SCL pulse. On any other value the block gives no acknowledge and ignores all further bytes until the next START, and storage stays unchanged.
- R3: A byte write is a device select with bit 0 = 0, an address byte and one data byte. It stores the data at that address, and the block acknowledges all three bytes.
- R4: Further data bytes in a write go to the next addresses. The low 4 address bits wrap inside the aligned 16-byte page and the upper bits are kept, so writing 4 bytes from 2Eh fills 2Eh, 2Fh, 20h, 21h and leaves 30h unchanged.
- R5: While `wr_lock` is 1, data bytes of a write are not acknowledged and nothing is stored. The device select and address bytes are still acknowledged.
- R6: A device select with bit 0 = 1 returns the byte at the internal address counter, MSB first. The counter then advances by one. The counter keeps its value across STOP, so back-to-back current reads return consecutive locations.
- R7: An address byte loads the counter. After a repeated START and a device select with bit 0 = 1, the byte at the loaded address is returned.
- R8: While the master acknowledges each read byte, the next address follows without a break, and address DEPTH-1 is followed by address 0.
- R9: If SDA is high when the ninth SCL pulse of a read byte rises, the block releases SDA and goes to standby. It drives nothing on later SCL pulses until a START.
- R10: Reads return the same data whether `wr_lock` is 0 or 1.
- R11: An SDA fall while SCL is high is a START, a repeated START included. An SDA rise while SCL is high is a STOP and returns the block to standby, keeping an address already loaded. SDA is sampled on the SCL rise and changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Level of the SCL line |
| sda_in | input | 1 | Level of the SDA line |
| wr_lock | input | 1 | 1 refuses data bytes of writes |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain enable) |

## Verification
The bench uses the default build: a 256-byte depth, a 16-byte page, bus address 50h and two synchroniser stages. With the full 8-bit depth, the counter rollover from FFh to 00h can be reached in a three-byte sequential read started at FEh. With the 16-byte page, a four-byte write started at 2Eh crosses the page edge. A quarter SCL period of eight system clocks leaves room for the synchroniser delay, so START and STOP can be told apart from data edges.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_ADDR,
    PH_WR,
    PH_RD
  } phase_t;

  // Device select comparison: upper seven bits carry the bus address.
  function automatic logic dev_match(input logic [7:0] sel, input logic [6:0] addr);
    return sel[7:1] == addr;
  endfunction

  // Read counter step, wrapping over the whole array.
  function automatic logic [7:0] seq_next(input logic [7:0] a, input logic [7:0] mask);
    return (a + 8'd1) & mask;
  endfunction

  // Write counter step, wrapping inside an aligned page.
  function automatic logic [7:0] page_next(input logic [7:0] a, input logic [7:0] pmask);
    return (a & ~pmask) | ((a + 8'd1) & pmask);
  endfunction

endpackage

// File: rtl/i2c_ee_line_sync.sv
module i2c_ee_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic scl_d, sda_d;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe[0] <= 1'b1;
          sda_pipe[0] <= 1'b1;
        end else begin
          scl_pipe[0] <= scl_in;
          sda_pipe[0] <= sda_in;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe[g] <= 1'b1;
          sda_pipe[g] <= 1'b1;
        end else begin
          scl_pipe[g] <= scl_pipe[g-1];
          sda_pipe[g] <= sda_pipe[g-1];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_s    = scl_pipe[STAGES-1];
  assign sda_s    = sda_pipe[STAGES-1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_ee_store.sv
module i2c_ee_store #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
    end else if (we) begin
      cells[addr] <= wdata;
    end
  end

  assign rdata = cells[addr];
endmodule

// File: rtl/i2c_ee_ctrl.sv
module i2c_ee_ctrl
  import i2c_ee_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter int DEPTH = 256,
  parameter int PAGE  = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_ev,
  input  logic          stop_ev,
  input  logic          wr_lock,
  input  logic [7:0]    rd_data,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          sda_pull,
  output logic          tx_load,
  output logic          nack_ev,
  output logic          dev_miss,
  output logic          phase_idle,
  output logic          phase_dev,
  output logic [7:0]    ptr
);
  localparam logic [7:0] DEPTH_MASK = 8'(DEPTH - 1);
  localparam logic [7:0] PAGE_MASK  = 8'(PAGE - 1);

  phase_t     phase_q;
  logic [3:0] cnt_q;
  logic       in_ack_q;
  logic [7:0] sh_q, tx_q, ptr_q;
  logic       pull_q;
  logic       rx_phase, byte_end, dev_hit;

  assign rx_phase = (phase_q == PH_DEV) || (phase_q == PH_ADDR) || (phase_q == PH_WR);
  assign byte_end = scl_fall && !in_ack_q && (cnt_q == 4'd8) && rx_phase;
  assign dev_hit  = byte_end && (phase_q == PH_DEV) && dev_match(sh_q, DEV_ADDR);
  assign dev_miss = byte_end && (phase_q == PH_DEV) && !dev_match(sh_q, DEV_ADDR);
  assign mem_we   = byte_end && (phase_q == PH_WR) && !wr_lock;
  assign tx_load  = scl_fall && in_ack_q && (phase_q == PH_RD);
  assign nack_ev  = scl_rise && in_ack_q && (phase_q == PH_RD) && sda_s;

  assign mem_addr   = ptr_q[AW-1:0];
  assign mem_wdata  = sh_q;
  assign sda_pull   = pull_q;
  assign phase_idle = (phase_q == PH_IDLE);
  assign phase_dev  = (phase_q == PH_DEV);
  assign ptr        = ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      cnt_q    <= '0;
      in_ack_q <= 1'b0;
      sh_q     <= '0;
      tx_q     <= '0;
      ptr_q    <= '0;
      pull_q   <= 1'b0;
    end else if (start_ev) begin
      phase_q  <= PH_DEV;
      cnt_q    <= '0;
      in_ack_q <= 1'b0;
      pull_q   <= 1'b0;
    end else if (stop_ev) begin
      phase_q  <= PH_IDLE;
      cnt_q    <= '0;
      in_ack_q <= 1'b0;
      pull_q   <= 1'b0;
    end else begin
      // bit counting on SCL rise
      if (scl_rise && !in_ack_q && (cnt_q < 4'd8) && (phase_q != PH_IDLE)) begin
        if (rx_phase) sh_q <= {sh_q[6:0], sda_s};
        cnt_q <= cnt_q + 4'd1;
      end
      // master withheld acknowledge
      if (nack_ev) begin
        phase_q  <= PH_IDLE;
        in_ack_q <= 1'b0;
        pull_q   <= 1'b0;
      end
      // received byte complete: decide acknowledge
      if (byte_end) begin
        in_ack_q <= 1'b1;
        unique case (phase_q)
          PH_DEV: begin
            if (dev_hit) begin
              pull_q  <= 1'b1;
              phase_q <= sh_q[0] ? PH_RD : PH_ADDR;
            end else begin
              phase_q  <= PH_IDLE;
              in_ack_q <= 1'b0;
            end
          end
          PH_ADDR: begin
            pull_q  <= 1'b1;
            ptr_q   <= sh_q & DEPTH_MASK;
            phase_q <= PH_WR;
          end
          PH_WR: begin
            if (!wr_lock) begin
              pull_q <= 1'b1;
              ptr_q  <= page_next(ptr_q, PAGE_MASK) & DEPTH_MASK;
            end
          end
          default: ;
        endcase
      end
      // end of the ninth bit
      if (scl_fall && in_ack_q && (phase_q != PH_IDLE)) begin
        in_ack_q <= 1'b0;
        cnt_q    <= '0;
        pull_q   <= 1'b0;
        if (phase_q == PH_RD) begin
          tx_q   <= rd_data;
          ptr_q  <= seq_next(ptr_q, DEPTH_MASK);
          pull_q <= ~rd_data[7];
        end
      end
      // read data bits after SCL fall
      if (scl_fall && !in_ack_q && (phase_q == PH_RD)) begin
        if (cnt_q < 4'd8) begin
          pull_q <= ~tx_q[3'd7 - cnt_q[2:0]];
        end else begin
          pull_q   <= 1'b0;
          in_ack_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target #(
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter int DEPTH       = 256,
  parameter int PAGE        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  input  logic wr_lock,
  output logic sda_pull
);
  localparam int AW = $clog2(DEPTH);

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic mem_we, tx_load, nack_ev, dev_miss, phase_idle, phase_dev;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, rd_data, ptr;

  i2c_ee_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  i2c_ee_ctrl #(.DEV_ADDR(DEV_ADDR), .DEPTH(DEPTH), .PAGE(PAGE)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
    .wr_lock(wr_lock), .rd_data(rd_data), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .sda_pull(sda_pull),
    .tx_load(tx_load), .nack_ev(nack_ev), .dev_miss(dev_miss),
    .phase_idle(phase_idle), .phase_dev(phase_dev), .ptr(ptr)
  );

  i2c_ee_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .addr(mem_addr),
    .wdata(mem_wdata), .rdata(rd_data)
  );
endmodule

// File: rtl/i2c_eeprom_checker.sv
module i2c_eeprom_checker #(
  parameter int DEPTH = 256,
  parameter int PAGE  = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_lock,
  input logic       sda_pull,
  input logic       scl_s,
  input logic       start_ev,
  input logic       mem_we,
  input logic       tx_load,
  input logic       nack_ev,
  input logic       dev_miss,
  input logic       phase_idle,
  input logic       phase_dev,
  input logic [7:0] ptr
);
  localparam logic [7:0] DMASK = 8'(DEPTH - 1);
  localparam int PW = $clog2(PAGE);

  // R5: nothing reaches the array while writes are locked
  a_r5_lock_blocks_store: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !wr_lock);

  // R11: the pull-down only moves while the synchronised SCL is low
  a_r11_pull_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !scl_s);

  // R11: a START always opens device selection
  a_r11_start_opens_select: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> phase_dev);

  // R8: each byte handed out advances the counter by one, modulo the depth
  a_r8_ptr_steps_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> ((ptr - $past(ptr)) & DMASK) == 8'd1);

  // R4: a stored byte never moves the counter to another page
  a_r4_page_base_kept: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (ptr >> PW) == ($past(ptr) >> PW));

  // R9: missing master acknowledge ends in standby with SDA released
  a_r9_nack_to_standby: assert property (@(posedge clk) disable iff (!rst_n)
    nack_ev |=> phase_idle && !sda_pull);

  // R2: a foreign device select leaves the bus alone
  a_r2_miss_to_standby: assert property (@(posedge clk) disable iff (!rst_n)
    dev_miss |=> phase_idle && !sda_pull);
endmodule

bind i2c_eeprom_target i2c_eeprom_checker #(.DEPTH(DEPTH), .PAGE(PAGE)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_lock(wr_lock), .sda_pull(sda_pull),
  .scl_s(scl_s), .start_ev(start_ev), .mem_we(mem_we), .tx_load(tx_load),
  .nack_ev(nack_ev), .dev_miss(dev_miss), .phase_idle(phase_idle),
  .phase_dev(phase_dev), .ptr(ptr)
);

// File: tb/sim_i2c_eeprom_target.sv
module sim_i2c_eeprom_target;
  localparam int Q = 8;
  localparam logic [7:0] SEL_W = 8'hA0;
  localparam logic [7:0] SEL_R = 8'hA1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic wr_lock = 1'b0;
  logic dut_pull;
  wire  sda_line = ~(m_low | dut_pull);

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  i2c_eeprom_target u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
    .wr_lock(wr_lock), .sda_pull(dut_pull)
  );

  task automatic wq(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    m_low = 1'b0; wq(Q);
    scl = 1'b1;   wq(Q);
    m_low = 1'b1; wq(Q);
    scl = 1'b0;   wq(Q);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; wq(Q);
    scl = 1'b1;   wq(Q);
    m_low = 1'b0; wq(2 * Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; wq(Q);
      scl = 1'b1;    wq(2 * Q);
      scl = 1'b0;    wq(Q);
    end
    m_low = 1'b0; wq(Q);
    scl = 1'b1;   wq(Q);
    acked = ~sda_line;
    wq(Q);
    scl = 1'b0;   wq(Q);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    b = '0;
    for (int i = 0; i < 8; i++) begin
      m_low = 1'b0; wq(Q);
      scl = 1'b1;   wq(Q);
      b = {b[6:0], sda_line};
      wq(Q);
      scl = 1'b0;   wq(Q);
    end
    m_low = give_ack; wq(Q);
    scl = 1'b1;       wq(2 * Q);
    scl = 1'b0;       wq(Q);
    m_low = 1'b0;
  endtask

  // Random read of n consecutive bytes; all acks are checked here
  task automatic rand_read(input logic [7:0] a, input int n, input string tag,
                           output logic [7:0] d0, output logic [7:0] d1, output logic [7:0] d2);
    bit ak;
    logic [7:0] v [3];
    bus_start();
    send_byte(SEL_W, ak); check(ak, {tag, " sel-w ack"}, ak, 1);
    send_byte(a, ak);     check(ak, {tag, " addr ack"}, ak, 1);
    bus_start();
    send_byte(SEL_R, ak); check(ak, {tag, " sel-r ack"}, ak, 1);
    for (int i = 0; i < n; i++) recv_byte(i != n - 1, v[i]);
    bus_stop();
    d0 = v[0]; d1 = v[1]; d2 = v[2];
  endtask

  task automatic cur_read(input string tag, output logic [7:0] d);
    bit ak;
    bus_start();
    send_byte(SEL_R, ak); check(ak, {tag, " sel-r ack"}, ak, 1);
    recv_byte(1'b0, d);
    bus_stop();
  endtask

  task automatic write_seq(input logic [7:0] a, input int n, input logic [7:0] base,
                           input string tag);
    bit ak;
    bus_start();
    send_byte(SEL_W, ak); check(ak, {tag, " sel-w ack"}, ak, 1);
    send_byte(a, ak);     check(ak, {tag, " addr ack"}, ak, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(base + 8'(i), ak);
      check(ak, {tag, " data ack"}, ak, 1);
    end
    bus_stop();
  endtask

  task automatic t_reset();
    logic [7:0] a, b, c;
    check(dut_pull == 1'b0, "R1 released after reset", dut_pull, 0);
    rand_read(8'h80, 1, "R1", a, b, c);
    check(a == 8'hFF, "R1 erased 80h", a, 8'hFF);
    rand_read(8'h00, 1, "R1", a, b, c);
    check(a == 8'hFF, "R1 erased 00h", a, 8'hFF);
  endtask

  task automatic t_byte_write();
    logic [7:0] a, b, c;
    write_seq(8'h10, 1, 8'h3C, "R3");
    rand_read(8'h10, 1, "R7", a, b, c);
    check(a == 8'h3C, "R3/R7 byte write readback", a, 8'h3C);
  endtask

  task automatic t_dev_miss();
    bit ak;
    logic [7:0] a, b, c;
    bus_start();
    send_byte(8'hA2, ak); check(!ak, "R2 foreign select not acked", ak, 0);
    send_byte(8'h10, ak); check(!ak, "R2 ignored address byte", ak, 0);
    send_byte(8'h77, ak); check(!ak, "R2 ignored data byte", ak, 0);
    bus_stop();
    rand_read(8'h10, 1, "R2", a, b, c);
    check(a == 8'h3C, "R2 storage untouched", a, 8'h3C);
  endtask

  task automatic t_page_write();
    logic [7:0] a, b, c;
    write_seq(8'h2E, 4, 8'hA0, "R4");
    rand_read(8'h2E, 3, "R4", a, b, c);
    check(a == 8'hA0, "R4 2Eh", a, 8'hA0);
    check(b == 8'hA1, "R4 2Fh", b, 8'hA1);
    check(c == 8'hFF, "R4 30h untouched", c, 8'hFF);
    rand_read(8'h20, 2, "R4", a, b, c);
    check(a == 8'hA2, "R4 wrapped to 20h", a, 8'hA2);
    check(b == 8'hA3, "R4 wrapped to 21h", b, 8'hA3);
  endtask

  task automatic t_current();
    logic [7:0] a, b, c;
    write_seq(8'h40, 3, 8'h11, "R6");
    rand_read(8'h40, 1, "R6", a, b, c);
    check(a == 8'h11, "R6 random start 40h", a, 8'h11);
    cur_read("R6", a);
    check(a == 8'h12, "R6 current read 41h", a, 8'h12);
    cur_read("R6", a);
    check(a == 8'h13, "R6 current read 42h", a, 8'h13);
  endtask

  task automatic t_stop_after_addr();
    bit ak;
    logic [7:0] a;
    write_seq(8'h51, 1, 8'hC3, "R11");
    bus_start();
    send_byte(SEL_W, ak); check(ak, "R11 sel-w ack", ak, 1);
    send_byte(8'h50, ak); check(ak, "R11 addr ack", ak, 1);
    bus_stop();
    cur_read("R11", a);
    check(a == 8'hFF, "R11 counter kept over STOP (50h)", a, 8'hFF);
    cur_read("R11", a);
    check(a == 8'hC3, "R11 next current read 51h", a, 8'hC3);
  endtask

  task automatic t_seq_wrap();
    logic [7:0] a, b, c;
    write_seq(8'hFF, 1, 8'h5A, "R8");
    write_seq(8'h00, 1, 8'h6B, "R8");
    rand_read(8'hFE, 3, "R8", a, b, c);
    check(a == 8'hFF, "R8 FEh", a, 8'hFF);
    check(b == 8'h5A, "R8 FFh", b, 8'h5A);
    check(c == 8'h6B, "R8 rollover to 00h", c, 8'h6B);
  endtask

  task automatic t_lock();
    bit ak;
    logic [7:0] a, b, c;
    wr_lock = 1'b1;
    bus_start();
    send_byte(SEL_W, ak); check(ak, "R5 sel acked under lock", ak, 1);
    send_byte(8'h10, ak); check(ak, "R5 addr acked under lock", ak, 1);
    send_byte(8'h99, ak); check(!ak, "R5 data refused under lock", ak, 0);
    bus_stop();
    rand_read(8'h10, 2, "R10", a, b, c);
    check(a == 8'h3C, "R5/R10 10h unchanged, read under lock", a, 8'h3C);
    check(b == 8'hFF, "R10 sequential under lock 11h", b, 8'hFF);
    wr_lock = 1'b0;
  endtask

  task automatic t_nack();
    bit ak;
    logic [7:0] a;
    int lows;
    bus_start();
    send_byte(SEL_W, ak); check(ak, "R9 sel-w ack", ak, 1);
    send_byte(8'h40, ak); check(ak, "R9 addr ack", ak, 1);
    bus_start();
    send_byte(SEL_R, ak); check(ak, "R9 sel-r ack", ak, 1);
    recv_byte(1'b0, a);
    check(a == 8'h11, "R9 data before nack", a, 8'h11);
    lows = 0;
    for (int i = 0; i < 9; i++) begin
      m_low = 1'b0; wq(Q);
      scl = 1'b1;   wq(Q);
      if (!sda_line) lows++;
      wq(Q);
      scl = 1'b0;   wq(Q);
    end
    check(lows == 0, "R9 no drive after nack", lows, 0);
    bus_stop();
  endtask

  initial begin
    wq(10);
    rst_n = 1'b1;
    wq(10);
    t_reset();
    t_byte_write();
    t_dev_miss();
    t_page_write();
    t_current();
    t_stop_after_addr();
    t_seq_wrap();
    t_lock();
    t_nack();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d (cycles)", 150000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule